// File: doc/BRIEF.md
# Directory Entry with Sticky Ownership

This block is the directory controller for one memory block in a directory-based MOESI coherence protocol. It records the block's state, which processor owns it and which processors share it, and it answers coherence messages with forwards, invalidations and data-from-memory responses. The memory array, the interconnect and the cache controllers sit outside the block.

It is extended for transactional memory, where a processor may evict data its running transaction has touched. A processor that sends a put request and then a transactional writeback of a Modified block stays recorded as owner, in a sticky state, even though it no longer holds a copy. Requests from other processors keep reaching it, so it can still report a conflict. The sticky state is not cleared when the transaction commits. It is cleared later, when the old owner answers a forwarded request with a clean reply. The directory then serves the requester from memory, which already holds the valid data.

The entry handles one transaction at a time. From a new request until its completion message arrives, the entry is busy and holds any further request at the input.

Top module: `dir_sticky_entry`

## Requirements
- R1: After reset the entry is idle (state code 0), the owner is 0, the sharer vector is 0, it is not busy, and the input is ready.
- R2: A GETX (input code 1) to an idle entry produces a DATA response (output code 0) to the requester on the next cycle. On the requester's ACK (code 6), the entry becomes Modified (state 4) with the requester as owner.
- R3: While the entry is Modified with owner P, a GETS (code 0) or GETX from another processor produces a forward (FWD_GETS, output code 1, or FWD_GETX, output code 2) addressed to P.
- R4: A PUTX (code 2) from the owner of a Modified entry is answered with PUT_ACK (output 3). The following transactional writeback (code 3) produces a memory write (output 4) and moves the entry to sticky-Modified (state 5), with the same owner and an empty sharer vector.
- R5: In the sticky-Modified state, a GETS or GETX from another processor is forwarded to the recorded owner.
- R6: A CLEAN (code 5) from the owner during a forwarded request produces a DATA response to the requester. The requester's ACK after a GETS then leaves the entry Exclusive (state 2), owned by the requester, with no sharers.
- R7: A NACK (code 7) from the requester ends the request and leaves state, owner and sharer vector unchanged.
- R8: While a request is outstanding, a new GETS, GETX or PUTX sees the input not ready, produces no output, and does not change the entry. It is taken after the ACK or NACK.
- R9: A GETX to a Shared (state 1) or Owned (state 3) entry raises an invalidation whose mask holds every recorded sharer except the requester and the owner. A processor that dropped a Shared copy without a message is still in that mask.
- R10: A put followed by a plain data writeback (code 4) from the owner of an Owned or Exclusive entry writes memory and leaves the entry Shared, with the writer added to the sharer vector.
- R11: A forwarded GETS on a Modified entry that completes with ACK and no CLEAN leaves the entry Owned by the old owner, with the requester added as a sharer.
- R12: CLEAN, ACK, NACK or writeback messages outside a matching outstanding request, and a PUTX from a processor that is not the owner, produce no output and leave the entry unchanged.
- R13: A GETX from the recorded owner of a sticky-Modified entry is served by a DATA response from memory, not a forward. The ACK leaves the entry Modified with that owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming message present |
| in_kind | input | 3 | Message code: 0 GETS, 1 GETX, 2 PUTX, 3 transactional writeback, 4 data writeback, 5 CLEAN, 6 ACK, 7 NACK |
| in_src | input | IDW (3) | Sending processor |
| in_ready | output | 1 | Message taken this cycle (low only for a request while busy) |
| out_valid | output | 1 | Outgoing message present (one-cycle pulse) |
| out_kind | output | 3 | 0 DATA, 1 FWD_GETS, 2 FWD_GETX, 3 PUT_ACK, 4 memory write |
| out_dst | output | IDW (3) | Destination processor (the writer, for a memory write) |
| inv_valid | output | 1 | Invalidation broadcast present |
| inv_mask | output | NPROC (8) | Processors to invalidate |
| dir_state | output | 3 | 0 idle, 1 Shared, 2 Exclusive, 3 Owned, 4 Modified, 5 sticky-Modified |
| dir_owner | output | IDW (3) | Recorded owner |
| dir_sharers | output | NPROC (8) | Sharer vector |
| dir_busy | output | 1 | A request is outstanding |

## Verification
The hardest situation to reach is a sticky-Modified entry that receives a request from another processor and is then cleared by a CLEAN reply. Getting there needs a full chain of messages: an exclusive fetch and its ACK, a put, a transactional writeback, and then the foreign request. The directed scenarios play that chain one message per cycle. They check the forward, the DATA produced by the CLEAN, and the final Exclusive state. One variant ends the chain with a NACK instead, and another has the old owner fetch its own block back. The silently dropped sharer is reached by building a Shared entry through an Owned writeback, adding a reader, and then issuing a GETX with no message from the dropping processor.

// File: rtl/dir_pkg.sv
package dir_pkg;

   typedef enum logic [2:0] {
      M_GETS  = 3'd0,
      M_GETX  = 3'd1,
      M_PUTX  = 3'd2,
      M_WBX   = 3'd3,
      M_WBD   = 3'd4,
      M_CLEAN = 3'd5,
      M_ACK   = 3'd6,
      M_NACK  = 3'd7
   } in_msg_e;

   typedef enum logic [2:0] {
      O_DATA     = 3'd0,
      O_FWD_GETS = 3'd1,
      O_FWD_GETX = 3'd2,
      O_PUT_ACK  = 3'd3,
      O_MEM_WR   = 3'd4
   } out_msg_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SHR  = 3'd1,
      ST_EXC  = 3'd2,
      ST_OWN  = 3'd3,
      ST_MOD  = 3'd4,
      ST_STKM = 3'd5
   } dir_state_e;

   typedef enum logic [1:0] {
      PEND_GETS = 2'd0,
      PEND_GETX = 2'd1,
      PEND_PUT  = 2'd2
   } pend_e;

   typedef enum logic [1:0] {
      SH_KEEP = 2'd0,
      SH_CLR  = 2'd1,
      SH_ADD  = 2'd2
   } sh_op_e;

   function automatic logic is_owned(input dir_state_e s);
      return (s == ST_EXC) || (s == ST_OWN) || (s == ST_MOD) || (s == ST_STKM);
   endfunction

endpackage

// File: rtl/dir_in_filter.sv
module dir_in_filter
   import dir_pkg::*;
#(
   parameter int NPROC = 8,
   localparam int IDW = $clog2(NPROC)
) (
   input  logic           in_valid,
   input  logic [2:0]     in_kind,
   input  logic [IDW-1:0] in_src,
   input  logic           busy,
   input  pend_e          pend_kind,
   input  logic [IDW-1:0] pend_src,
   input  logic           pend_fwd,
   input  logic           cleaned,
   input  logic [IDW-1:0] owner,
   output logic           in_ready,
   output logic           go_req,
   output logic           go_ack,
   output logic           go_nack,
   output logic           go_clean,
   output logic           go_wbx,
   output logic           go_wbd
);
   logic is_req, acc, from_pend, pend_rd;
   in_msg_e k;

   always_comb begin
      k         = in_msg_e'(in_kind);
      is_req    = (k == M_GETS) || (k == M_GETX) || (k == M_PUTX);
      in_ready  = !busy || !is_req;
      acc       = in_valid && in_ready;
      from_pend = busy && (in_src == pend_src);
      pend_rd   = pend_kind != PEND_PUT;
      go_req    = acc && is_req;
      go_ack    = acc && from_pend && pend_rd && (k == M_ACK);
      go_nack   = acc && from_pend && pend_rd && (k == M_NACK);
      go_clean  = acc && busy && pend_rd && pend_fwd && !cleaned &&
                  (k == M_CLEAN) && (in_src == owner);
      go_wbx    = acc && from_pend && !pend_rd && (k == M_WBX);
      go_wbd    = acc && from_pend && !pend_rd && (k == M_WBD);
   end
endmodule

// File: rtl/dir_sharer_reg.sv
module dir_sharer_reg
   import dir_pkg::*;
#(
   parameter int NPROC = 8,
   localparam int IDW = $clog2(NPROC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sh_op_e           op,
   input  logic [IDW-1:0]   id,
   output logic [NPROC-1:0] sharers
);
   for (genvar i = 0; i < NPROC; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            sharers[i] <= 1'b0;
         else if (op == SH_CLR)
            sharers[i] <= 1'b0;
         else if (op == SH_ADD && id == IDW'(i))
            sharers[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/dir_entry_ctrl.sv
module dir_entry_ctrl
   import dir_pkg::*;
#(
   parameter int NPROC = 8,
   localparam int IDW = $clog2(NPROC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       in_kind,
   input  logic [IDW-1:0]   in_src,
   input  logic             go_req,
   input  logic             go_ack,
   input  logic             go_nack,
   input  logic             go_clean,
   input  logic             go_wbx,
   input  logic             go_wbd,
   input  logic [NPROC-1:0] sharers,
   output sh_op_e           sh_op,
   output logic [IDW-1:0]   sh_id,
   output dir_state_e       state,
   output logic [IDW-1:0]   owner,
   output logic             busy,
   output pend_e            pend_kind,
   output logic [IDW-1:0]   pend_src,
   output logic             pend_fwd,
   output logic             cleaned,
   output logic             out_valid,
   output out_msg_e         out_kind,
   output logic [IDW-1:0]   out_dst,
   output logic             inv_valid,
   output logic [NPROC-1:0] inv_mask
);
   dir_state_e       st_n;
   logic [IDW-1:0]   own_n, ps_n, od_n;
   logic             busy_n, pf_n, cl_n, ov_n, iv_n;
   pend_e            pk_n;
   out_msg_e         ok_n;
   logic [NPROC-1:0] im_n, others;
   logic             want_x;

   always_comb begin
      st_n = state; own_n = owner; busy_n = busy; pk_n = pend_kind;
      ps_n = pend_src; pf_n = pend_fwd; cl_n = cleaned;
      sh_op = SH_KEEP; sh_id = pend_src;
      ov_n = 1'b0; ok_n = O_DATA; od_n = in_src; iv_n = 1'b0; im_n = '0;
      want_x = in_msg_e'(in_kind) == M_GETX;
      others = sharers & ~(NPROC'(1) << in_src);
      if (go_req) begin
         if (in_msg_e'(in_kind) == M_PUTX) begin
            if (is_owned(state) && state != ST_STKM && owner == in_src) begin
               busy_n = 1'b1; pk_n = PEND_PUT; ps_n = in_src;
               pf_n = 1'b0; cl_n = 1'b0;
               ov_n = 1'b1; ok_n = O_PUT_ACK;
            end
         end else begin
            busy_n = 1'b1; ps_n = in_src; cl_n = 1'b0;
            pk_n = want_x ? PEND_GETX : PEND_GETS;
            ov_n = 1'b1;
            if (is_owned(state) && owner != in_src) begin
               pf_n = 1'b1;
               ok_n = want_x ? O_FWD_GETX : O_FWD_GETS;
               od_n = owner;
               others = others & ~(NPROC'(1) << owner);
            end else begin
               pf_n = 1'b0;
               ok_n = O_DATA;
            end
            if (want_x && others != '0) begin
               iv_n = 1'b1; im_n = others;
            end
         end
      end else if (go_clean) begin
         ov_n = 1'b1; ok_n = O_DATA; od_n = pend_src; cl_n = 1'b1;
      end else if (go_nack) begin
         busy_n = 1'b0;
      end else if (go_ack) begin
         busy_n = 1'b0;
         if (pend_kind == PEND_GETX) begin
            st_n = ST_MOD; own_n = pend_src; sh_op = SH_CLR;
         end else if (cleaned) begin
            st_n = ST_EXC; own_n = pend_src; sh_op = SH_CLR;
         end else if (!pend_fwd) begin
            if (state == ST_IDLE) begin
               st_n = ST_EXC; own_n = pend_src;
            end else if (state == ST_SHR) begin
               sh_op = SH_ADD;
            end
         end else begin
            st_n = ST_OWN; sh_op = SH_ADD;
         end
      end else if (go_wbx || go_wbd) begin
         busy_n = 1'b0; ov_n = 1'b1; ok_n = O_MEM_WR; od_n = pend_src;
         if (go_wbx && state == ST_MOD) begin
            st_n = ST_STKM; sh_op = SH_CLR;
         end else if (state == ST_MOD) begin
            st_n = ST_IDLE; own_n = '0; sh_op = SH_CLR;
         end else begin
            st_n = ST_SHR; own_n = '0; sh_op = SH_ADD;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE; owner <= '0; busy <= 1'b0; pend_kind <= PEND_GETS;
         pend_src <= '0; pend_fwd <= 1'b0; cleaned <= 1'b0;
         out_valid <= 1'b0; out_kind <= O_DATA; out_dst <= '0;
         inv_valid <= 1'b0; inv_mask <= '0;
      end else begin
         state <= st_n; owner <= own_n; busy <= busy_n; pend_kind <= pk_n;
         pend_src <= ps_n; pend_fwd <= pf_n; cleaned <= cl_n;
         out_valid <= ov_n; out_kind <= ok_n; out_dst <= od_n;
         inv_valid <= iv_n; inv_mask <= im_n;
      end
   end

   // R8
   req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_req |-> !busy);

   // R4
   sticky_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_wbx && state == ST_MOD) |=> (state == ST_STKM && owner == $past(owner)));

   // R7
   nack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_nack |=> ($stable(state) && $stable(owner) && $stable(sharers)));

   // R3
   fwd_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_kind == O_FWD_GETS || out_kind == O_FWD_GETX)) |-> out_dst == owner);

   // R6
   clean_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_clean |=> (out_valid && out_kind == O_DATA && out_dst == pend_src));

   // R12
   one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({go_req, go_ack, go_nack, go_clean, go_wbx, go_wbd}));
endmodule

// File: rtl/dir_sticky_entry.sv
module dir_sticky_entry
   import dir_pkg::*;
#(
   parameter int NPROC = 8,
   localparam int IDW = $clog2(NPROC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       in_kind,
   input  logic [IDW-1:0]   in_src,
   output logic             in_ready,
   output logic             out_valid,
   output logic [2:0]       out_kind,
   output logic [IDW-1:0]   out_dst,
   output logic             inv_valid,
   output logic [NPROC-1:0] inv_mask,
   output logic [2:0]       dir_state,
   output logic [IDW-1:0]   dir_owner,
   output logic [NPROC-1:0] dir_sharers,
   output logic             dir_busy
);
   if (NPROC < 2) begin : g_bad_nproc
      $error("dir_sticky_entry: NPROC must be at least 2");
   end

   logic           go_req, go_ack, go_nack, go_clean, go_wbx, go_wbd;
   logic           busy, pend_fwd, cleaned;
   pend_e          pend_kind;
   logic [IDW-1:0] pend_src, owner, sh_id;
   sh_op_e         sh_op;
   dir_state_e     state;
   out_msg_e       okind;
   logic [NPROC-1:0] sharers;

   dir_in_filter #(.NPROC(NPROC)) u_filter (
      .in_valid(in_valid), .in_kind(in_kind), .in_src(in_src),
      .busy(busy), .pend_kind(pend_kind), .pend_src(pend_src),
      .pend_fwd(pend_fwd), .cleaned(cleaned), .owner(owner),
      .in_ready(in_ready), .go_req(go_req), .go_ack(go_ack),
      .go_nack(go_nack), .go_clean(go_clean), .go_wbx(go_wbx), .go_wbd(go_wbd)
   );

   dir_sharer_reg #(.NPROC(NPROC)) u_sharers (
      .clk(clk), .rst_n(rst_n), .op(sh_op), .id(sh_id), .sharers(sharers)
   );

   dir_entry_ctrl #(.NPROC(NPROC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .in_kind(in_kind), .in_src(in_src),
      .go_req(go_req), .go_ack(go_ack), .go_nack(go_nack),
      .go_clean(go_clean), .go_wbx(go_wbx), .go_wbd(go_wbd),
      .sharers(sharers), .sh_op(sh_op), .sh_id(sh_id),
      .state(state), .owner(owner), .busy(busy), .pend_kind(pend_kind),
      .pend_src(pend_src), .pend_fwd(pend_fwd), .cleaned(cleaned),
      .out_valid(out_valid), .out_kind(okind), .out_dst(out_dst),
      .inv_valid(inv_valid), .inv_mask(inv_mask)
   );

   assign out_kind    = okind;
   assign dir_state   = state;
   assign dir_owner   = owner;
   assign dir_sharers = sharers;
   assign dir_busy    = busy;
endmodule

// File: tb/dir_sticky_entry_test.sv
module dir_sticky_entry_test;
   localparam int NPROC = 8;
   localparam int IDW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [2:0] in_kind = '0;
   logic [IDW-1:0] in_src = '0;
   logic in_ready, out_valid, inv_valid, dir_busy;
   logic [2:0] out_kind, dir_state;
   logic [IDW-1:0] out_dst, dir_owner;
   logic [NPROC-1:0] inv_mask, dir_sharers;

   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   dir_sticky_entry #(.NPROC(NPROC)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
      .in_src(in_src), .in_ready(in_ready), .out_valid(out_valid),
      .out_kind(out_kind), .out_dst(out_dst), .inv_valid(inv_valid),
      .inv_mask(inv_mask), .dir_state(dir_state), .dir_owner(dir_owner),
      .dir_sharers(dir_sharers), .dir_busy(dir_busy)
   );

   localparam int GETS = 0, GETX = 1, PUTX = 2, WBX = 3, WBD = 4,
                  CLEAN = 5, ACK = 6, NACK = 7;
   localparam int DATA = 0, FGETS = 1, FGETX = 2, PACK = 3, MWR = 4;

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send(input int k, input int s);
      @(negedge clk);
      in_valid = 1'b1; in_kind = 3'(k); in_src = 3'(s);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic exp_msg(input string r, input int k, input int d);
      chk({r, " out_valid"}, int'(out_valid), 1);
      chk({r, " out_kind"}, int'(out_kind), k);
      chk({r, " out_dst"}, int'(out_dst), d);
   endtask

   task automatic exp_quiet(input string r);
      chk({r, " no out_valid"}, int'(out_valid), 0);
      chk({r, " no inv_valid"}, int'(inv_valid), 0);
   endtask

   task automatic exp_dir(input string r, input int st, input int own, input int sh, input int b);
      chk({r, " state"}, int'(dir_state), st);
      chk({r, " owner"}, int'(dir_owner), own);
      chk({r, " sharers"}, int'(dir_sharers), sh);
      chk({r, " busy"}, int'(dir_busy), b);
   endtask

   task automatic make_mod(input int p);
      send(GETX, p); send(ACK, p);
   endtask

   task automatic make_sticky(input int p);
      make_mod(p); send(PUTX, p); send(WBX, p);
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      exp_dir("R1 reset", 0, 0, 0, 0);
      chk("R1 ready", int'(in_ready), 1);
      exp_quiet("R1 reset");
   endtask

   task automatic t_getx_idle();
      do_reset();
      send(GETX, 2); exp_msg("R2 getx idle", DATA, 2);
      chk("R2 no inv", int'(inv_valid), 0);
      exp_dir("R2 busy", 0, 0, 0, 1);
      send(ACK, 2); exp_dir("R2 after ack", 4, 2, 0, 0);
   endtask

   task automatic t_fwd_mod();
      do_reset();
      make_mod(1);
      send(GETS, 3); exp_msg("R3 fwd gets", FGETS, 1);
      send(ACK, 3); exp_dir("R11 owned", 3, 1, 8'h08, 0);
      send(GETX, 4); exp_msg("R3 fwd getx", FGETX, 1);
      chk("R9 owned inv valid", int'(inv_valid), 1);
      chk("R9 owned inv mask", int'(inv_mask), 8'h08);
      send(ACK, 4); exp_dir("R9 getx done", 4, 4, 0, 0);
   endtask

   task automatic t_sticky();
      do_reset();
      make_mod(2);
      send(PUTX, 2); exp_msg("R4 putx", PACK, 2);
      send(WBX, 2); exp_msg("R4 wbx", MWR, 2);
      exp_dir("R4 sticky", 5, 2, 0, 0);
      send(GETX, 6); exp_msg("R5 sticky fwd getx", FGETX, 2);
      send(NACK, 6); exp_quiet("R7 nack");
      exp_dir("R7 unchanged", 5, 2, 0, 0);
      send(GETS, 5); exp_msg("R5 sticky fwd gets", FGETS, 2);
      send(CLEAN, 2); exp_msg("R6 clean data", DATA, 5);
      send(ACK, 5); exp_dir("R6 exclusive", 2, 5, 0, 0);
   endtask

   task automatic t_busy();
      do_reset();
      send(GETX, 1);
      @(negedge clk);
      in_valid = 1'b1; in_kind = 3'(GETS); in_src = 3'd2;
      #1 chk("R8 ready low", int'(in_ready), 0);
      @(posedge clk); #1;
      exp_quiet("R8 held");
      exp_dir("R8 held", 0, 0, 0, 1);
      in_valid = 1'b0;
      send(ACK, 1); exp_dir("R8 release", 4, 1, 0, 0);
      send(GETS, 2); exp_msg("R8 taken later", FGETS, 1);
   endtask

   task automatic t_shared();
      do_reset();
      send(GETS, 0); exp_msg("R9 gets idle", DATA, 0);
      send(ACK, 0); exp_dir("R9 excl", 2, 0, 0, 0);
      send(GETS, 1); exp_msg("R9 fwd from excl", FGETS, 0);
      send(ACK, 1); exp_dir("R11 owned from excl", 3, 0, 8'h02, 0);
      send(PUTX, 0); exp_msg("R10 putx owned", PACK, 0);
      send(WBD, 0); exp_msg("R10 wbd", MWR, 0);
      exp_dir("R10 shared", 1, 0, 8'h03, 0);
      send(GETS, 2); exp_msg("R9 gets shared", DATA, 2);
      send(ACK, 2); exp_dir("R9 shared add", 1, 0, 8'h07, 0);
      // processor 1 drops its copy silently: no message
      send(GETX, 3); exp_msg("R9 getx shared", DATA, 3);
      chk("R9 inv valid", int'(inv_valid), 1);
      chk("R9 inv mask keeps silent sharer", int'(inv_mask), 8'h07);
      send(ACK, 3); exp_dir("R9 mod", 4, 3, 0, 0);
      do_reset();
      send(GETS, 6); send(ACK, 6);
      send(PUTX, 6); send(WBD, 6);
      exp_dir("R10 excl writeback", 1, 0, 8'h40, 0);
   endtask

   task automatic t_stray();
      do_reset();
      send(CLEAN, 3); exp_quiet("R12 stray clean");
      send(ACK, 3); exp_quiet("R12 stray ack");
      exp_dir("R12 idle kept", 0, 0, 0, 0);
      make_mod(1);
      send(PUTX, 5); exp_quiet("R12 putx non-owner");
      exp_dir("R12 mod kept", 4, 1, 0, 0);
      send(GETS, 4); send(ACK, 7); exp_quiet("R12 wrong acker");
      exp_dir("R12 still busy", 4, 1, 0, 1);
      send(NACK, 4);
   endtask

   task automatic t_refetch();
      do_reset();
      make_sticky(2);
      send(GETX, 2); exp_msg("R13 owner refetch", DATA, 2);
      send(ACK, 2); exp_dir("R13 mod again", 4, 2, 0, 0);
   endtask

   initial begin
      fork
         begin
            t_reset(); t_getx_idle(); t_fwd_mod(); t_sticky();
            t_busy(); t_shared(); t_stray(); t_refetch();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule